// File: doc/BRIEF.md
# I/O ports with key-scan interrupts

This peripheral sits on the internal register bus of a small controller. It provides three 8-bit bidirectional ports and one 8-bit input-only key-scan port. Software sets each bidirectional pin separately as a high-impedance input or as a push-pull output. Each bidirectional port has a data register and a direction register. The key-scan port has a pull-up enable for each pin, and any falling edge on it raises a dedicated interrupt flag.

Four pins of the second bidirectional port (D) are interrupt sources with a fixed polarity. Bits 2 and 4 fire on a rising edge, and bits 3 and 5 fire on a falling edge. Every input is synchronised through two flops. An edge only counts if the level before it was held for at least two clocks.

A comparator-enable bit hands D4 and D5 to an external comparator. While it is set, their drivers are forced off and their edge interrupts are suppressed. The synchronised comparator result then raises its own interrupt on a rising edge. All interrupt flags are sticky, and software clears a flag by writing 1 to its bit.

Top module: `pio_keyscan`

## Requirements
- R1: After a synchronous active-low reset, all data and direction registers, the pull-up enables, the comparator enable and all interrupt flags are 0, so no pin is driven.
- R2: For each bidirectional port p (C=0, D=1, E=2), the data register is at address 0x10+8p and the direction register at 0x14+8p. `pin_out` follows the data register. A direction bit of 1 drives `pin_oe` for that pin. The outputs change on the clock edge that takes the write.
- R3: A read of a data register returns the latched data bit for output pins and the synchronised pin level for input pins. The synchronised level lags the pin by two clocks. A read of a direction register returns the register.
- R4: A rising edge on D2 sets flag bit 0, and a rising edge on D4 sets flag bit 2. The flag is visible after the third clock edge that samples the new level.
- R5: A falling edge on D3 sets flag bit 1, and a falling edge on D5 sets flag bit 3, with the same latency as R4.
- R6: The key port reads at 0x28. Its effective pin value is the pin where it is driven. An undriven pin reads 1 if its pull-up enable is set; the enables are at 0x29, bit i for pin i. A falling edge on any effective key pin sets flag bit 4.
- R7: Flags are sticky and read at 0x2B. Writing 1 to a flag bit clears it, and writing 0 leaves it alone. A set in the same cycle wins over a clear.
- R8: When bit 0 of 0x2A (comparator enable, also driven on `cmp_enable`) is 1, D4 and D5 are not driven, read as inputs, and set no flags. A rising edge of the synchronised `cmp_result` then sets flag bit 5. While the enable is 0, flag bit 5 is never set.
- R9: An edge counts only when the opposite level was present for at least two synchronised samples before it. A one-clock pulse sets no flag, and a two-clock pulse does.
- R10: Registers 0x29, 0x2A and 0x2B read back their contents. A read of any unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 24 | Bidirectional pad inputs, port C in [7:0], D in [15:8], E in [23:16] |
| pin_out | output | 24 | Pad output values, same layout |
| pin_oe | output | 24 | Pad output enables, same layout |
| key_in | input | 8 | Key-scan pad values |
| key_driven | input | 8 | 1 where the key pad is actively driven from outside |
| cmp_result | input | 1 | Result from the external comparator |
| cmp_enable | output | 1 | Comparator enable towards the analog side |
| irq_pend | output | 6 | Sticky interrupt flags |

## Verification
The hardest cases to reach are the edge-qualification boundaries, because they depend on how many sampling edges see a level. A one-clock pulse must be ignored while a two-clock pulse must count. The bench drives pins a fixed 2 ns after a clock edge and holds them for an exact count of edges. It does this for both polarities, and also while the comparator owns D4 and D5. A queue-based reference model of the sampled history predicts every output on every clock.

// File: rtl/pio_keyscan_pkg.sv
// Shared constants for the port block: register map, pin roles, flag order.
package pio_keyscan_pkg;
    localparam int FLAG_N        = 6;
    localparam int FL_RISE_A     = 0;   // D2 rising
    localparam int FL_FALL_A     = 1;   // D3 falling
    localparam int FL_RISE_B     = 2;   // D4 rising
    localparam int FL_FALL_B     = 3;   // D5 falling
    localparam int FL_KEY        = 4;   // any key pin falling
    localparam int FL_CMP        = 5;   // comparator result rising

    localparam int PORT_BASE     = 'h10;
    localparam int PORT_STRIDE   = 8;
    localparam int CTL_OFFSET    = 4;
    localparam int ADDR_KEY_IN   = 'h28;
    localparam int ADDR_KEY_PU   = 'h29;
    localparam int ADDR_CMP_CTL  = 'h2A;
    localparam int ADDR_FLAGS    = 'h2B;

    localparam int EDGE_PORT     = 1;   // port D carries the edge sources
    localparam int BIT_RISE_A    = 2;
    localparam int BIT_FALL_A    = 3;
    localparam int BIT_CMP_LO    = 4;   // rising source, comparator input
    localparam int BIT_CMP_HI    = 5;   // falling source, comparator input
endpackage

// File: rtl/pio_sync_edge.sv
// Two-flop synchroniser followed by a level-qualified edge detector.
// Assumes raw inputs are asynchronous; an edge is reported only when the
// previous two synchronised samples both held the opposite level.
module pio_sync_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q, lvl_q, h1_q, h2_q;

    // Shift the raw value through the sync chain and the history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_q  <= '0;
            h1_q   <= '0;
            h2_q   <= '0;
        end else begin
            meta_q <= raw;
            lvl_q  <= meta_q;
            h1_q   <= lvl_q;
            h2_q   <= h1_q;
        end
    end

    assign level = lvl_q;
    assign rise  = lvl_q & ~h1_q & ~h2_q;
    assign fall  = ~lvl_q & h1_q & h2_q;
endmodule

// File: rtl/pio_bidir_port.sv
// One bidirectional port: data and direction registers plus read-back mux.
// Assumes pin_level is already synchronised; force_off masks drivers that
// another function has taken over, and such pins read as inputs.
module pio_bidir_port #(
    parameter int                W         = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR = '0,
    parameter logic [ADDR_W-1:0] CTL_ADDR  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      pin_level,
    input  logic [W-1:0]      force_off,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      rdata
);
    logic [W-1:0] data_q, dir_q, eff_dir;

    // Capture software writes to the data and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == DATA_ADDR) data_q <= bus_wdata;
            if (bus_addr == CTL_ADDR)  dir_q  <= bus_wdata;
        end
    end

    assign eff_dir = dir_q & ~force_off;
    assign pin_out = data_q;
    assign pin_oe  = eff_dir;

    // Select read-back: latched bits for outputs, pin level for inputs.
    always_comb begin
        rdata = '0;
        if (bus_addr == DATA_ADDR)     rdata = (data_q & eff_dir) | (pin_level & ~eff_dir);
        else if (bus_addr == CTL_ADDR) rdata = dir_q;
    end
endmodule

// File: rtl/pio_irq_flags.sv
// Sticky interrupt flags with write-one-to-clear; a set beats a clear.
module pio_irq_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_q;

    // Hold each flag until cleared, giving new events priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags = flags_q;
endmodule

// File: rtl/pio_keyscan.sv
// Top of the port block: bidirectional ports, key-scan port with pull-ups,
// fixed-polarity edge interrupts and the comparator hand-over of D4/D5.
// Assumes a single clock; all pad inputs are asynchronous.
module pio_keyscan
    import pio_keyscan_pkg::*;
#(
    parameter int PORT_W  = 8,
    parameter int N_BIDIR = 3,
    parameter int ADDR_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [PORT_W-1:0]         bus_wdata,
    output logic [PORT_W-1:0]         bus_rdata,
    input  logic [N_BIDIR*PORT_W-1:0] pin_in,
    output logic [N_BIDIR*PORT_W-1:0] pin_out,
    output logic [N_BIDIR*PORT_W-1:0] pin_oe,
    input  logic [PORT_W-1:0]         key_in,
    input  logic [PORT_W-1:0]         key_driven,
    input  logic                      cmp_result,
    output logic                      cmp_enable,
    output logic [FLAG_N-1:0]         irq_pend
);
    localparam int                NB       = N_BIDIR * PORT_W;
    localparam int                DB       = EDGE_PORT * PORT_W;
    localparam logic [ADDR_W-1:0] A_KEY    = ADDR_W'(ADDR_KEY_IN);
    localparam logic [ADDR_W-1:0] A_PU     = ADDR_W'(ADDR_KEY_PU);
    localparam logic [ADDR_W-1:0] A_CMP    = ADDR_W'(ADDR_CMP_CTL);
    localparam logic [ADDR_W-1:0] A_FLAGS  = ADDR_W'(ADDR_FLAGS);

    logic [NB-1:0]     bid_lvl, bid_rise, bid_fall;
    logic [PORT_W-1:0] key_eff, key_lvl, key_rise, key_fall;
    logic              cmp_lvl, cmp_rise, cmp_fall;
    logic [PORT_W-1:0] pu_q;
    logic              cmp_q;
    logic [PORT_W-1:0] cmp_mask;
    logic [PORT_W-1:0] port_rd [N_BIDIR];
    logic [FLAG_N-1:0] set_v, clr_v, flags;

    // Undriven key pins read high where their pull-up is enabled.
    assign key_eff = key_in | (~key_driven & pu_q);

    pio_sync_edge #(.W(NB)) u_bid_sync (
        .clk(clk), .rst_n(rst_n), .raw(pin_in),
        .level(bid_lvl), .rise(bid_rise), .fall(bid_fall)
    );

    pio_sync_edge #(.W(PORT_W)) u_key_sync (
        .clk(clk), .rst_n(rst_n), .raw(key_eff),
        .level(key_lvl), .rise(key_rise), .fall(key_fall)
    );

    pio_sync_edge #(.W(1)) u_cmp_sync (
        .clk(clk), .rst_n(rst_n), .raw(cmp_result),
        .level(cmp_lvl), .rise(cmp_rise), .fall(cmp_fall)
    );

    // Build the driver mask for the pins the comparator owns.
    always_comb begin
        cmp_mask             = '0;
        cmp_mask[BIT_CMP_LO] = cmp_q;
        cmp_mask[BIT_CMP_HI] = cmp_q;
    end

    for (genvar p = 0; p < N_BIDIR; p++) begin : g_port
        localparam logic [ADDR_W-1:0] DA = ADDR_W'(PORT_BASE + p * PORT_STRIDE);
        localparam logic [ADDR_W-1:0] CA = ADDR_W'(PORT_BASE + p * PORT_STRIDE + CTL_OFFSET);
        logic [PORT_W-1:0] force_v;
        assign force_v = (p == EDGE_PORT) ? cmp_mask : '0;

        pio_bidir_port #(
            .W(PORT_W), .ADDR_W(ADDR_W), .DATA_ADDR(DA), .CTL_ADDR(CA)
        ) u_port (
            .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
            .bus_wdata(bus_wdata),
            .pin_level(bid_lvl[p*PORT_W +: PORT_W]),
            .force_off(force_v),
            .pin_out(pin_out[p*PORT_W +: PORT_W]),
            .pin_oe(pin_oe[p*PORT_W +: PORT_W]),
            .rdata(port_rd[p])
        );
    end

    // Capture the pull-up enables and the comparator enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu_q  <= '0;
            cmp_q <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == A_PU)  pu_q  <= bus_wdata;
            if (bus_addr == A_CMP) cmp_q <= bus_wdata[0];
        end
    end

    // Gather interrupt events; comparator ownership gates D4/D5 sources.
    always_comb begin
        set_v            = '0;
        set_v[FL_RISE_A] = bid_rise[DB + BIT_RISE_A];
        set_v[FL_FALL_A] = bid_fall[DB + BIT_FALL_A];
        set_v[FL_RISE_B] = bid_rise[DB + BIT_CMP_LO] & ~cmp_q;
        set_v[FL_FALL_B] = bid_fall[DB + BIT_CMP_HI] & ~cmp_q;
        set_v[FL_KEY]    = |key_fall;
        set_v[FL_CMP]    = cmp_rise & cmp_q;
        clr_v            = (bus_wr && bus_addr == A_FLAGS) ? bus_wdata[FLAG_N-1:0] : '0;
    end

    pio_irq_flags #(.N(FLAG_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .flags(flags)
    );

    // Merge read data from every register source.
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < N_BIDIR; p++) bus_rdata = bus_rdata | port_rd[p];
        if (bus_addr == A_KEY)   bus_rdata = key_lvl;
        if (bus_addr == A_PU)    bus_rdata = pu_q;
        if (bus_addr == A_CMP)   bus_rdata = PORT_W'(cmp_q);
        if (bus_addr == A_FLAGS) bus_rdata = PORT_W'(flags);
    end

    assign cmp_enable = cmp_q;
    assign irq_pend   = flags;

    // The falling edges of the comparator path and the rising edges of the
    // key path have no consumer.
    logic unused_ok;
    assign unused_ok = &{1'b0, cmp_lvl, cmp_fall, key_rise};
endmodule

// File: rtl/pio_keyscan_chk.sv
// Property checker for the port block, attached to every instance by bind.
module pio_keyscan_chk
    import pio_keyscan_pkg::*;
#(
    parameter int PORT_W  = 8,
    parameter int N_BIDIR = 3,
    parameter int ADDR_W  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [N_BIDIR*PORT_W-1:0] pin_oe,
    input logic                      cmp_enable,
    input logic [FLAG_N-1:0]         irq_pend
);
    localparam int                DB      = EDGE_PORT * PORT_W;
    localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(ADDR_FLAGS);

    assert_cmp_drv_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_enable |-> (!pin_oe[DB + BIT_CMP_LO] && !pin_oe[DB + BIT_CMP_HI]));

    assert_oe_write_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> $stable(pin_oe));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(bus_wr) && $past(bus_addr) == A_FLAGS)
        |-> ((irq_pend & $past(irq_pend)) == $past(irq_pend)));

    assert_cmp_flag_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend[FL_CMP]) |-> $past(cmp_enable));

    assert_d4_flag_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend[FL_RISE_B]) |-> !$past(cmp_enable));
endmodule

bind pio_keyscan pio_keyscan_chk #(
    .PORT_W(PORT_W), .N_BIDIR(N_BIDIR), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .pin_oe(pin_oe), .cmp_enable(cmp_enable), .irq_pend(irq_pend)
);

// File: tb/pio_keyscan_tb.sv
// Bench: behavioural history-queue model compared every clock, plus
// directed checks against constants taken from the requirements.
module pio_keyscan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [23:0] pin_in = 24'h0;
    logic [23:0] pin_out, pin_oe;
    logic [7:0]  key_in = 8'hFF;
    logic [7:0]  key_driven = 8'hFF;
    logic        cmp_result = 1'b0;
    logic        cmp_enable;
    logic [5:0]  irq_pend;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pio_keyscan u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .key_in(key_in),
        .key_driven(key_driven), .cmp_result(cmp_result),
        .cmp_enable(cmp_enable), .irq_pend(irq_pend)
    );

    // Reference model state; index 0 of each history is the newest sample.
    logic [7:0]  m_data [3];
    logic [7:0]  m_dir  [3];
    logic [7:0]  m_pu;
    logic        m_cmp;
    logic [5:0]  m_flags;
    logic [23:0] hb [4];
    logic [7:0]  hk [4];
    logic        hc [4];

    function automatic logic [7:0] m_eff_dir(input int p);
        logic [7:0] f = 8'h00;
        if (p == 1 && m_cmp) f = 8'h30;
        return m_dir[p] & ~f;
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] a);
        for (int p = 0; p < 3; p++) begin
            if (a == 8'(16 + 8 * p))
                return (m_data[p] & m_eff_dir(p)) | (hb[1][p*8 +: 8] & ~m_eff_dir(p));
            if (a == 8'(20 + 8 * p)) return m_dir[p];
        end
        if (a == 8'h28) return hk[1];
        if (a == 8'h29) return m_pu;
        if (a == 8'h2A) return {7'b0, m_cmp};
        if (a == 8'h2B) return {2'b0, m_flags};
        return 8'h00;
    endfunction

    // Advance the model on each clock edge using pre-edge inputs.
    always @(posedge clk) begin
        logic [5:0] setv, clrv;
        if (!rst_n) begin
            for (int p = 0; p < 3; p++) begin m_data[p] = 0; m_dir[p] = 0; end
            m_pu = 0; m_cmp = 0; m_flags = 0;
            for (int i = 0; i < 4; i++) begin hb[i] = 0; hk[i] = 0; hc[i] = 0; end
        end else begin
            setv[0] = hb[1][10] & ~hb[2][10] & ~hb[3][10];
            setv[1] = ~hb[1][11] & hb[2][11] & hb[3][11];
            setv[2] = hb[1][12] & ~hb[2][12] & ~hb[3][12] & ~m_cmp;
            setv[3] = ~hb[1][13] & hb[2][13] & hb[3][13] & ~m_cmp;
            setv[4] = |(~hk[1] & hk[2] & hk[3]);
            setv[5] = hc[1] & ~hc[2] & ~hc[3] & m_cmp;
            clrv = (bus_wr && bus_addr == 8'h2B) ? bus_wdata[5:0] : 6'h0;
            for (int i = 3; i > 0; i--) begin hb[i] = hb[i-1]; hk[i] = hk[i-1]; hc[i] = hc[i-1]; end
            hb[0] = pin_in;
            hk[0] = key_in | (~key_driven & m_pu);
            hc[0] = cmp_result;
            m_flags = (m_flags & ~clrv) | setv;
            if (bus_wr) begin
                for (int p = 0; p < 3; p++) begin
                    if (bus_addr == 8'(16 + 8 * p)) m_data[p] = bus_wdata;
                    if (bus_addr == 8'(20 + 8 * p)) m_dir[p] = bus_wdata;
                end
                if (bus_addr == 8'h29) m_pu = bus_wdata;
                if (bus_addr == 8'h2A) m_cmp = bus_wdata[0];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare every output with the model in the middle of each cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 model pin_out", pin_out, {m_data[2], m_data[1], m_data[0]});
            chk("R2 model pin_oe", pin_oe, {m_eff_dir(2), m_eff_dir(1), m_eff_dir(0)});
            chk("R7 model irq_pend", 32'(irq_pend), 32'(m_flags));
            chk("R3 model bus_rdata", 32'(bus_rdata), 32'(m_read(bus_addr)));
            chk("R8 model cmp_enable", 32'(cmp_enable), 32'(m_cmp));
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        step(1);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
        bus_addr = a;
        @(negedge clk);
        chk(tag, 32'(bus_rdata), 32'(exp));
        step(1);
        bus_addr = 8'h00;
    endtask

    task automatic see(input string tag, input logic [31:0] act, input logic [31:0] exp);
        @(negedge clk);
        chk(tag, act, exp);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        see("R1 reset oe", pin_oe, 24'h0);
        see("R1 reset out", pin_out, 24'h0);
        see("R1 reset flags", 32'(irq_pend), 0);
        see("R1 reset cmp", 32'(cmp_enable), 0);

        wr(8'h14, 8'hF0); wr(8'h10, 8'hA5);
        see("R2 port C out", 32'(pin_out[7:0]), 8'hA5);
        see("R2 port C oe", 32'(pin_oe[7:0]), 8'hF0);
        wr(8'h24, 8'hFF); wr(8'h20, 8'h5A);
        see("R2 port E out", 32'(pin_out[23:16]), 8'h5A);
        see("R2 port E oe", 32'(pin_oe[23:16]), 8'hFF);

        pin_in[7:0] = 8'h3C;
        step(3);
        rd("R3 mixed read C", 8'h10, 8'hAC);
        rd("R3 dir read C", 8'h14, 8'hF0);
        rd("R10 unmapped read", 8'h50, 8'h00);

        pin_in[10] = 1'b1; pin_in[12] = 1'b1;
        step(4);
        see("R4 D2 rise flag", 32'(irq_pend[0]), 1);
        see("R4 D4 rise flag", 32'(irq_pend[2]), 1);
        wr(8'h2B, 8'h01);
        see("R7 clear bit 0", 32'(irq_pend[0]), 0);
        see("R7 bit 2 kept", 32'(irq_pend[2]), 1);
        rd("R10 flag readback", 8'h2B, 8'h04);
        wr(8'h2B, 8'h3F);

        pin_in[11] = 1'b1; pin_in[13] = 1'b1;
        step(4);
        see("R5 no flag on rise", 32'(irq_pend), 0);
        pin_in[11] = 1'b0; pin_in[13] = 1'b0;
        step(4);
        see("R5 D3 fall flag", 32'(irq_pend[1]), 1);
        see("R5 D5 fall flag", 32'(irq_pend[3]), 1);
        wr(8'h2B, 8'h3F);

        step(3);
        pin_in[11] = 1'b1; step(1); pin_in[11] = 1'b0;
        step(5);
        see("R9 one-clock pulse ignored", 32'(irq_pend[1]), 0);
        pin_in[11] = 1'b1; step(2); pin_in[11] = 1'b0;
        step(5);
        see("R9 two-clock pulse counted", 32'(irq_pend[1]), 1);
        wr(8'h2B, 8'h3F);

        step(2);
        rd("R6 key all high", 8'h28, 8'hFF);
        key_driven[3] = 1'b0; key_in[3] = 1'b0;
        step(4);
        see("R6 key fall flag", 32'(irq_pend[4]), 1);
        rd("R6 undriven no pull-up", 8'h28, 8'hF7);
        wr(8'h2B, 8'h10);
        wr(8'h29, 8'h08);
        step(3);
        rd("R6 pull-up reads 1", 8'h28, 8'hFF);
        see("R6 no flag on rise", 32'(irq_pend[4]), 0);
        rd("R10 pull-up readback", 8'h29, 8'h08);
        key_in[6] = 1'b0;
        step(4);
        see("R6 driven key fall", 32'(irq_pend[4]), 1);
        wr(8'h2B, 8'h3F);

        pin_in[12] = 1'b0;
        step(4);
        wr(8'h2A, 8'h01);
        wr(8'h1C, 8'hFF); wr(8'h18, 8'h00);
        see("R8 D4/D5 drivers off", 32'(pin_oe[15:8]), 8'hCF);
        rd("R10 cmp readback", 8'h2A, 8'h01);
        pin_in[15:8] = 8'h10;
        step(4);
        see("R8 D4 rise suppressed", 32'(irq_pend[2]), 0);
        rd("R8 D4 reads pin", 8'h18, 8'h10);
        pin_in[13] = 1'b1; step(4); pin_in[13] = 1'b0;
        step(4);
        see("R8 D5 fall suppressed", 32'(irq_pend[3]), 0);
        cmp_result = 1'b1;
        step(4);
        see("R8 comparator flag", 32'(irq_pend[5]), 1);
        wr(8'h2B, 8'h20);
        cmp_result = 1'b0;
        step(4);
        wr(8'h2A, 8'h00);
        cmp_result = 1'b1;
        step(5);
        see("R8 comparator off no flag", 32'(irq_pend[5]), 0);
        see("R8 D4/D5 drive restored", 32'(pin_oe[15:8]), 8'hFF);

        step(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule